// File: doc/BRIEF.md
# Expansion-Bus Command Cycle Sequencer

This block turns a decoded CPU cycle request into a timed command on an 8/16-bit expansion bus. A request carries a cycle kind (memory, I/O or interrupt acknowledge), a direction, a width flag, an address and write data. The block answers with one of five active-low command strobes, the byte-select address bit, a lane-swap enable, write data lanes and a one-bus-clock ready pulse that carries the assembled read data back to the CPU.

Two 8-bit wait-state registers, one for memory and one for I/O, are written over a small configuration port. They set extra clocks before the strobe and extra clocks of strobe width, and the memory register also has a fast option. The channel-ready input stretches any strobe. A 16-bit access to a device that does not claim 16-bit capability is broken into a low-byte and a high-byte command. The low read byte is held until the second half completes. Memory reads in a fixed boot-ROM window get their own short timing. All state advances only on clocks where the bus clock enable is high, so every duration below is counted in bus clocks.

Top module: `xbus_cmd_seq`

## Requirements
- R1: After reset all five strobes are high, ready, swap_en and hold_block are low, and both configuration registers read 00h.
- R2: cfg_sel=0 selects the memory register and cfg_sel=1 selects the I/O register, and both reset to 00h. Bits 7:6 of each register give 0-3 extra strobe clocks and bits 5:4 give 0-3 extra setup clocks. Bit 3 of the memory register is the fast flag. Memory bits 2:0 and I/O bits 3:0 always read 0.
- R3: A memory command (req_kind=2'b00) that is neither a ROM read nor a 16-bit-capable wide access has 1+mem[5:4] setup clocks and a strobe of 5+mem[7:6] clocks. The strobe is 3 clocks shorter when mem[3] is 1. MRD is used for reads and MWR for writes.
- R4: An I/O command (req_kind=2'b01) that is not a 16-bit-capable wide access has 1+io[5:4] setup clocks and a strobe of 5+io[7:6] clocks. Every I/O cycle ends with 3 strobe-free recovery clocks before ready.
- R5: The strobe never ends on a bus clock where chrdy is sampled low. Once chrdy has been low, the strobe lasts at least 3 clocks counted from the first clock chrdy is seen high again, and never less than its programmed width.
- R6: A wide access with dev16_n high is split into two commands of equal timing, separated by 3 strobe-free clocks. The first command has bus_a0=0 and the second has bus_a0=1 with swap_en=1. Read data is {low lane at end of second, low lane at end of first}. Write lanes carry req_wdata in the first command and {req_wdata[15:8], req_wdata[15:8]} in the second.
- R7: A wide memory or I/O access with dev16_n low is a single command with 1 setup clock, a 2-clock strobe and bus_a0=0. It returns the whole 16-bit lane.
- R8: Interrupt acknowledge (req_kind=2'b10) gives two INTA strobes, each 1 setup clock plus 2 clocks wide, with a 3-clock gap between them. hold_block is high exactly during that gap. Read data is {8'h00, low lane at end of the second pulse}.
- R9: A memory read to 0E0000h-0FFFFFh has 1 setup clock and a 2+mem[7:6]-clock MRD strobe. It is never split, the fast flag and mem[5:4] do not change it, and it returns the whole lane.
- R10: After the last phase, ready is high for exactly one bus clock. The block then returns to idle and accepts the next request on the following bus clock.
- R11: At most one strobe is low at any time, and it matches the kind and direction of the request. A narrow access drives bus_a0 from req_addr[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_en | input | 1 | Bus clock enable; the sequencer advances only when high |
| req_valid | input | 1 | Cycle request, taken when idle |
| req_kind | input | 2 | 00 memory, 01 I/O, 10 interrupt acknowledge |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 16-bit access |
| req_addr | input | 24 | Cycle address |
| req_wdata | input | 16 | Write data |
| dev16_n | input | 1 | Low when the addressed device is 16-bit capable |
| chrdy | input | 1 | Channel ready; low stretches the strobe |
| bus_rdata | input | 16 | Read data lanes from the bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 memory wait register, 1 I/O wait register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register |
| mrd_n | output | 1 | Memory read strobe |
| mwr_n | output | 1 | Memory write strobe |
| iord_n | output | 1 | I/O read strobe |
| iowr_n | output | 1 | I/O write strobe |
| inta_n | output | 1 | Interrupt acknowledge strobe |
| bus_a0 | output | 1 | Byte-select address bit |
| swap_en | output | 1 | Low lane routed to high lane (second half of a split) |
| bus_wdata | output | 16 | Write data lanes |
| hold_block | output | 1 | Blocks bus-hold grant between INTA pulses |
| ready | output | 1 | One-bus-clock cycle completion to the CPU |
| rdata | output | 16 | Assembled read data, valid with ready |

## Verification
The bench steps through every memory and I/O wait-register code with the fast flag on and off, and checks setup and strobe length clock by clock. A design that subtracts the fast reduction from the setup count, or that applies it to ROM reads, fails those comparisons. Random runs with chrdy held low let the bench confirm that no strobe closes on a low sample, and that the three-clock tail after release is kept even when the programmed width would already have run out. Split reads and writes check the A0 order, the lane swap and the recovery gap, and a design that returns the high byte in the wrong half shows a wrong rdata. INTA and I/O cycles check that hold_block covers exactly the gap between pulses and that the I/O recovery comes before ready rather than after it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    parameter int CNT_W      = 4;
    parameter int RECOV_CLKS = 3;
    parameter int TAIL_MIN   = 3;
    parameter int BASE_CMD   = 5;
    parameter int FAST_CUT   = 3;
    parameter int PULSE_W    = 2;
    parameter int ONE_WS_W   = 2;
    parameter int ROM_BASE_W = 2;

    typedef enum logic [1:0] {
        K_MEM  = 2'b00,
        K_IO   = 2'b01,
        K_INTA = 2'b10
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CMD,
        PH_RECOV,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        FM_FULL,
        FM_SPLIT,
        FM_VEC
    } fmode_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] width;
        logic             split;
        logic             tail;
        logic             two;
        fmode_e           fmode;
    } plan_t;
endpackage

// File: rtl/xbus_wait_regs.sv
module xbus_wait_regs #(
    parameter int               CFG_W    = 8,
    parameter logic [CFG_W-1:0] MEM_KEEP = 8'hF8,
    parameter logic [CFG_W-1:0] IO_KEEP  = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] mem_cfg,
    output logic [CFG_W-1:0] io_cfg,
    output logic [CFG_W-1:0] cfg_rdata
);
    typedef struct packed {
        logic [CFG_W-1:0] mem;
        logic [CFG_W-1:0] io;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            if (cfg_sel) r_d.io  = cfg_wdata & IO_KEEP;
            else         r_d.mem = cfg_wdata & MEM_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_cfg   = r_q.mem;
    assign io_cfg    = r_q.io;
    assign cfg_rdata = cfg_sel ? r_q.io : r_q.mem;

    assert_cfg_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_cfg & ~MEM_KEEP) == '0) && ((io_cfg & ~IO_KEEP) == '0));
endmodule

// File: rtl/xbus_timing.sv
module xbus_timing
    import xbus_pkg::*;
#(
    parameter int                ADDR_W = 24,
    parameter int                CFG_W  = 8,
    parameter logic [ADDR_W-1:0] ROM_LO = 'h0E0000,
    parameter logic [ADDR_W-1:0] ROM_HI = 'h0FFFFF
) (
    input  kind_e             req_kind,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              dev16_n,
    input  logic [CFG_W-1:0]  mem_cfg,
    input  logic [CFG_W-1:0]  io_cfg,
    output plan_t             plan
);
    localparam int CMD_LSB  = 6;
    localparam int PRE_LSB  = 4;
    localparam int FAST_BIT = 3;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] BASE  = CNT_W'(BASE_CMD);
    localparam logic [CNT_W-1:0] CUT   = CNT_W'(FAST_CUT);

    logic             in_rom;
    logic             cap16;
    logic [CNT_W-1:0] mem_w, mem_s, io_w, io_s, rom_w;

    always_comb begin
        in_rom = (req_kind == K_MEM) && !req_write &&
                 (req_addr >= ROM_LO) && (req_addr <= ROM_HI);
        cap16  = req_wide && !dev16_n;
        mem_w  = BASE + CNT_W'(mem_cfg[CMD_LSB +: 2]) - (mem_cfg[FAST_BIT] ? CUT : '0);
        mem_s  = ONE + CNT_W'(mem_cfg[PRE_LSB +: 2]);
        io_w   = BASE + CNT_W'(io_cfg[CMD_LSB +: 2]);
        io_s   = ONE + CNT_W'(io_cfg[PRE_LSB +: 2]);
        rom_w  = CNT_W'(ROM_BASE_W) + CNT_W'(mem_cfg[CMD_LSB +: 2]);

        plan       = '0;
        plan.setup = ONE;
        plan.fmode = FM_FULL;
        unique case (req_kind)
            K_INTA: begin
                plan.width = CNT_W'(PULSE_W);
                plan.two   = 1'b1;
                plan.fmode = FM_VEC;
            end
            K_IO: begin
                plan.tail = 1'b1;
                if (cap16) begin
                    plan.width = CNT_W'(ONE_WS_W);
                end else begin
                    plan.setup = io_s;
                    plan.width = io_w;
                    plan.split = req_wide;
                end
            end
            default: begin
                if (in_rom) begin
                    plan.width = rom_w;
                end else if (cap16) begin
                    plan.width = CNT_W'(ONE_WS_W);
                end else begin
                    plan.setup = mem_s;
                    plan.width = mem_w;
                    plan.split = req_wide;
                end
            end
        endcase
        if (plan.split) plan.fmode = FM_SPLIT;
    end
endmodule

// File: rtl/xbus_rdpath.sv
module xbus_rdpath
    import xbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_low,
    input  logic              cap_fin,
    input  fmode_e            fmode,
    input  logic [DATA_W-1:0] lane,
    output logic [DATA_W-1:0] rdata
);
    localparam int BYTE = DATA_W / 2;

    typedef struct packed {
        logic [BYTE-1:0]   low;
        logic [DATA_W-1:0] out;
    } rd_t;

    rd_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (cap_low) d_d.low = lane[BYTE-1:0];
        if (cap_fin) begin
            unique case (fmode)
                FM_SPLIT: d_d.out = {lane[BYTE-1:0], d_q.low};
                FM_VEC:   d_d.out = {{BYTE{1'b0}}, lane[BYTE-1:0]};
                default:  d_d.out = lane;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign rdata = d_q.out;

    assert_no_dual_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_low && cap_fin));
endmodule

// File: rtl/xbus_cmd_seq.sv
module xbus_cmd_seq
    import xbus_pkg::*;
#(
    parameter int                ADDR_W = 24,
    parameter int                DATA_W = 16,
    parameter int                CFG_W  = 8,
    parameter logic [ADDR_W-1:0] ROM_LO = 'h0E0000,
    parameter logic [ADDR_W-1:0] ROM_HI = 'h0FFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dev16_n,
    input  logic              chrdy,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              mrd_n,
    output logic              mwr_n,
    output logic              iord_n,
    output logic              iowr_n,
    output logic              inta_n,
    output logic              bus_a0,
    output logic              swap_en,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              hold_block,
    output logic              ready,
    output logic [DATA_W-1:0] rdata
);
    localparam int BYTE = DATA_W / 2;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] RECOV = CNT_W'(RECOV_CLKS);
    localparam logic [CNT_W-1:0] TAIL  = CNT_W'(TAIL_MIN);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  width;
        logic              half;
        logic              split;
        logic              tail;
        logic              two;
        logic              in_tail;
        logic              wr;
        logic              a0;
        kind_e             kind;
        fmode_e            fmode;
        logic [DATA_W-1:0] wdata;
    } st_t;

    st_t              s_d, s_q;
    plan_t            plan;
    logic [CFG_W-1:0] mem_cfg, io_cfg;
    logic             cap_low, cap_fin;
    logic [CNT_W-1:0] nxt;
    logic             cmd_on;
    logic [4:0]       stb_vec;

    xbus_wait_regs #(.CFG_W(CFG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_cfg(mem_cfg), .io_cfg(io_cfg),
        .cfg_rdata(cfg_rdata)
    );

    xbus_timing #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) u_timing (
        .req_kind(kind_e'(req_kind)), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .dev16_n(dev16_n), .mem_cfg(mem_cfg),
        .io_cfg(io_cfg), .plan(plan)
    );

    xbus_rdpath #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .cap_low(cap_low), .cap_fin(cap_fin),
        .fmode(s_q.fmode), .lane(bus_rdata), .rdata(rdata)
    );

    always_comb begin
        s_d     = s_q;
        cap_low = 1'b0;
        cap_fin = 1'b0;
        nxt     = s_q.cnt - ONE;
        if (bclk_en) begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        s_d.phase   = PH_SETUP;
                        s_d.cnt     = plan.setup;
                        s_d.width   = plan.width;
                        s_d.split   = plan.split;
                        s_d.tail    = plan.tail;
                        s_d.two     = plan.two;
                        s_d.fmode   = plan.fmode;
                        s_d.half    = 1'b0;
                        s_d.in_tail = 1'b0;
                        s_d.kind    = kind_e'(req_kind);
                        s_d.wr      = req_write;
                        s_d.a0      = req_wide ? 1'b0 : req_addr[0];
                        s_d.wdata   = req_wdata;
                    end
                end
                PH_SETUP: begin
                    if (s_q.cnt == ONE) begin
                        s_d.phase = PH_CMD;
                        s_d.cnt   = s_q.width;
                    end else begin
                        s_d.cnt = nxt;
                    end
                end
                PH_CMD: begin
                    if (s_q.cnt == ONE && chrdy) begin
                        if ((s_q.split || s_q.two) && !s_q.half) begin
                            cap_low   = 1'b1;
                            s_d.phase = PH_RECOV;
                            s_d.cnt   = RECOV;
                            s_d.half  = 1'b1;
                        end else begin
                            cap_fin = 1'b1;
                            if (s_q.tail) begin
                                s_d.phase   = PH_RECOV;
                                s_d.cnt     = RECOV;
                                s_d.in_tail = 1'b1;
                            end else begin
                                s_d.phase = PH_DONE;
                            end
                        end
                    end else if (!chrdy && nxt < TAIL) begin
                        s_d.cnt = TAIL;
                    end else begin
                        s_d.cnt = nxt;
                    end
                end
                PH_RECOV: begin
                    if (s_q.cnt == ONE) begin
                        if (s_q.in_tail) begin
                            s_d.phase = PH_DONE;
                        end else begin
                            s_d.phase = PH_CMD;
                            s_d.cnt   = s_q.width;
                        end
                    end else begin
                        s_d.cnt = nxt;
                    end
                end
                PH_DONE: begin
                    s_d.phase   = PH_IDLE;
                    s_d.in_tail = 1'b0;
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_on     = (s_q.phase == PH_CMD);
    assign mrd_n      = !(cmd_on && s_q.kind == K_MEM && !s_q.wr);
    assign mwr_n      = !(cmd_on && s_q.kind == K_MEM &&  s_q.wr);
    assign iord_n     = !(cmd_on && s_q.kind == K_IO  && !s_q.wr);
    assign iowr_n     = !(cmd_on && s_q.kind == K_IO  &&  s_q.wr);
    assign inta_n     = !(cmd_on && s_q.kind == K_INTA);
    assign bus_a0     = s_q.split ? s_q.half : s_q.a0;
    assign swap_en    = cmd_on && s_q.split && s_q.half;
    assign bus_wdata  = (s_q.split && s_q.half) ?
                        {s_q.wdata[DATA_W-1:BYTE], s_q.wdata[DATA_W-1:BYTE]} : s_q.wdata;
    assign hold_block = (s_q.phase == PH_RECOV) && s_q.two && !s_q.in_tail;
    assign ready      = (s_q.phase == PH_DONE);
    assign stb_vec    = ~{mrd_n, mwr_n, iord_n, iowr_n, inta_n};

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_vec));
    assert_ready_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bclk_en) |=> !ready);
    assert_chrdy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && bclk_en && !chrdy) |=> (stb_vec != 5'b0));
    assert_hold_gap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_block |-> (stb_vec == 5'b0) && !ready);
    assert_swap_high_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |-> bus_a0);
endmodule

// File: tb/tb_xbus_cmd_seq.sv
module tb_xbus_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        dev16_n = 1'b1;
    logic        chrdy = 1'b1;
    logic [15:0] bus_rdata = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        mrd_n, mwr_n, iord_n, iowr_n, inta_n;
    logic        bus_a0, swap_en, hold_block, ready;
    logic [15:0] bus_wdata, rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem_sh = 8'h00;
    logic [7:0] io_sh  = 8'h00;

    int   q_stb[$];
    bit   q_a0[$], q_swap[$], q_hold[$], q_rdy[$], q_half[$], q_chr[$];
    logic [15:0] q_wd[$];

    always #4 clk = ~clk;
    always @(negedge clk) if (rst_n) bclk_en <= ~bclk_en;

    xbus_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .req_valid(req_valid),
        .req_kind(req_kind), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .dev16_n(dev16_n),
        .chrdy(chrdy), .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mrd_n(mrd_n), .mwr_n(mwr_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .inta_n(inta_n), .bus_a0(bus_a0),
        .swap_en(swap_en), .bus_wdata(bus_wdata), .hold_block(hold_block),
        .ready(ready), .rdata(rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic next_bus();
        do @(posedge clk); while (bclk_en !== 1'b1);
        @(negedge clk);
    endtask

    task automatic cfg_write(bit sel, logic [7:0] v);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) io_sh = v & 8'hF0; else mem_sh = v & 8'hF8;
    endtask

    task automatic push(int stb, bit a0, bit sw, bit hold, bit rdy, bit half, bit c, logic [15:0] wd);
        q_stb.push_back(stb); q_a0.push_back(a0); q_swap.push_back(sw);
        q_hold.push_back(hold); q_rdy.push_back(rdy); q_half.push_back(half);
        q_chr.push_back(c); q_wd.push_back(wd);
    endtask

    task automatic run(string tag, int kind, bit wr, bit wide, logic [23:0] addr,
                       logic [15:0] wd, bit d16n, int stretch);
        bit rom, split, tail, cap16;
        int setup, width, halves, stb, rem, lows;
        logic [15:0] d0, d1, exp_rd;
        bit c;
        q_stb.delete(); q_a0.delete(); q_swap.delete(); q_hold.delete();
        q_rdy.delete(); q_half.delete(); q_chr.delete(); q_wd.delete();
        rom   = (kind == 0) && !wr && addr >= 24'h0E0000 && addr <= 24'h0FFFFF;
        cap16 = wide && !d16n;
        split = 0; tail = (kind == 1); halves = 1; setup = 1;
        if (kind == 2) begin width = 2; halves = 2; end
        else if (kind == 0 && rom) width = 2 + mem_sh[7:6];
        else if (cap16) width = 2;
        else if (kind == 0) begin
            setup = 1 + mem_sh[5:4];
            width = 5 + mem_sh[7:6] - (mem_sh[3] ? 3 : 0);
            split = wide;
        end else begin
            setup = 1 + io_sh[5:4];
            width = 5 + io_sh[7:6];
            split = wide;
        end
        if (split) halves = 2;
        stb = (kind == 2) ? 1 : (kind == 1) ? (wr ? 2 : 4) : (wr ? 8 : 16);
        d0 = 16'($urandom); d1 = 16'($urandom);
        for (int i = 0; i < setup; i++) push(0, 0, 0, 0, 0, 0, 1, wd);
        for (int h = 0; h < halves; h++) begin
            if (h == 1) for (int i = 0; i < 3; i++) push(0, 0, 0, kind == 2, 0, 1, 1, wd);
            rem = width; lows = 0;
            forever begin
                c = !(stretch > 0 && lows < stretch && $urandom_range(0, 2) == 0);
                if (!c) lows++;
                push(stb, split ? h[0] : (wide ? 1'b0 : addr[0]), split && h == 1, 0, 0,
                     h[0], c, (split && h == 1) ? {wd[15:8], wd[15:8]} : wd);
                if (rem == 1 && c) break;
                rem = c ? rem - 1 : ((rem - 1 < 3) ? 3 : rem - 1);
            end
        end
        if (tail) for (int i = 0; i < 3; i++) push(0, 0, 0, 0, 0, 1, 1, wd);
        push(0, 0, 0, 0, 1, 1, 1, wd);
        if (kind == 2) exp_rd = {8'h00, d1[7:0]};
        else if (split) exp_rd = {d1[7:0], d0[7:0]};
        else exp_rd = d0;

        req_valid = 1; req_kind = 2'(kind); req_write = wr; req_wide = wide;
        req_addr = addr; req_wdata = wd; dev16_n = d16n;
        next_bus();
        req_valid = 0;
        for (int k = 0; k < q_stb.size(); k++) begin
            chrdy = q_chr[k];
            bus_rdata = (q_half[k] && halves == 2) ? d1 : d0;
            chk({tag, " R11 strobes/ready/hold"},
                {24'd0, ~mrd_n, ~mwr_n, ~iord_n, ~iowr_n, ~inta_n, swap_en, hold_block, ready},
                {24'd0, 5'(q_stb[k]), q_swap[k], q_hold[k], q_rdy[k]});
            if (q_stb[k] != 0) chk({tag, " R11 bus_a0"}, {31'd0, bus_a0}, {31'd0, q_a0[k]});
            if (q_stb[k] != 0 && wr) chk({tag, " R6 write lanes"}, {16'd0, bus_wdata}, {16'd0, q_wd[k]});
            if (q_rdy[k] && !wr) chk({tag, " rdata"}, {16'd0, rdata}, {16'd0, exp_rd});
            next_bus();
        end
        chrdy = 1;
        chk({tag, " R10 back to idle"},
            {27'd0, ~mrd_n, ~mwr_n, ~iord_n, ~iowr_n, ~inta_n} | {29'd0, hold_block, ready, swap_en},
            32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 strobes idle after reset", {27'd0, mrd_n, mwr_n, iord_n, iowr_n, inta_n}, 32'h1F);
        chk("R1 ready/swap/hold low", {29'd0, ready, swap_en, hold_block}, 32'd0);
        cfg_sel = 0; #1 chk("R1 memory register reset", {24'd0, cfg_rdata}, 32'd0);
        cfg_sel = 1; #1 chk("R1 io register reset", {24'd0, cfg_rdata}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        cfg_write(0, 8'hFF); cfg_sel = 0; #1 chk("R2 memory bits 2:0 zero", {24'd0, cfg_rdata}, 32'hF8);
        cfg_write(1, 8'hFF); cfg_sel = 1; #1 chk("R2 io bits 3:0 zero", {24'd0, cfg_rdata}, 32'hF0);
        cfg_write(0, 8'h5A); cfg_sel = 0; #1 chk("R2 memory fields", {24'd0, cfg_rdata}, 32'h58);
        @(negedge clk);
        next_bus();

        for (int w = 0; w < 4; w++)
            for (int p = 0; p < 4; p++)
                for (int f = 0; f < 2; f++) begin
                    cfg_write(0, {2'(w), 2'(p), 1'(f), 3'b000});
                    run("R3 mem read", 0, 0, 0, 24'h000101, 16'h0000, 1, 0);
                    run("R3 mem write", 0, 1, 0, 24'h000200, 16'h1234, 1, 0);
                end
        for (int w = 0; w < 4; w++)
            for (int p = 0; p < 4; p++) begin
                cfg_write(1, {2'(w), 2'(p), 4'b0000});
                run("R4 io read", 1, 0, 0, 24'h000061, 16'h0000, 1, 0);
                run("R4 io write", 1, 1, 0, 24'h000080, 16'h00C3, 1, 0);
            end

        cfg_write(0, 8'h48); cfg_write(1, 8'h90);
        for (int i = 0; i < 6; i++) begin
            run("R5 mem read stretch", 0, 0, 0, 24'h000300, 16'h0, 1, 6);
            run("R5 io write stretch", 1, 1, 0, 24'h000300, 16'hBEEF, 1, 5);
            run("R5 split read stretch", 0, 0, 1, 24'h000400, 16'h0, 1, 4);
            run("R5 inta stretch", 2, 0, 0, 24'h0, 16'h0, 1, 4);
        end

        cfg_write(0, 8'h10); cfg_write(1, 8'h00);
        run("R6 mem split read", 0, 0, 1, 24'h000500, 16'h0, 1, 0);
        run("R6 mem split write", 0, 1, 1, 24'h000500, 16'hA55A, 1, 0);
        run("R6 io split read", 1, 0, 1, 24'h000300, 16'h0, 1, 0);
        run("R6 io split write", 1, 1, 1, 24'h000300, 16'h7E81, 1, 0);

        cfg_write(0, 8'hF0); cfg_write(1, 8'hF0);
        run("R7 mem 16-bit device read", 0, 0, 1, 24'h000600, 16'h0, 0, 0);
        run("R7 mem 16-bit device write", 0, 1, 1, 24'h000600, 16'h3C3C, 0, 0);
        run("R7 io 16-bit device read", 1, 0, 1, 24'h000300, 16'h0, 0, 0);

        run("R8 inta pair", 2, 0, 0, 24'h0, 16'h0, 1, 0);
        run("R8 inta pair again", 2, 0, 0, 24'h0, 16'h0, 1, 0);

        cfg_write(0, 8'hB8);
        run("R9 rom low edge", 0, 0, 1, 24'h0E0000, 16'h0, 1, 0);
        run("R9 rom high edge", 0, 0, 1, 24'h0FFFFF, 16'h0, 1, 0);
        run("R9 below rom splits", 0, 0, 1, 24'h0DFFFF, 16'h0, 1, 0);
        run("R9 rom write is normal", 0, 1, 0, 24'h0E0001, 16'h55AA, 1, 0);
        cfg_write(0, 8'h08);
        run("R9 rom fast ignored", 0, 0, 0, 24'h0F0000, 16'h0, 1, 0);

        run("R10 back-to-back one", 1, 0, 0, 24'h000020, 16'h0, 1, 0);
        run("R10 back-to-back two", 0, 1, 0, 24'h000021, 16'h0F0F, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule